// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous SRAM core whose read and write data phases both fall exactly two clock edges after the command edge. Because a write's address and lane mask wait in the pipeline until its data shows up, a read may follow a write, or a write a read, on every cycle with no idle slot on the data bus. Each word is 36 bits, made of four 9-bit lanes. Each lane holds eight data bits plus one parity bit. A write can update any subset of the lanes.

A command either loads a new address or continues a four-word burst from the last loaded address. The burst runs in linear (add) or interleaved (xor) order. A hold input freezes the whole core. Three select inputs gate the start of a new command. The bidirectional data bus is split into an input word, an output word and an output-enable. An asynchronous gate input can force the output-enable off at any time.

Top module: `zbt_sram`

## Requirements
- R1: A read command registered at rising edge k drives `rdata` with the addressed word and raises `rdata_oe` after enabled edge k+2. A write command registered at edge k takes `wdata` at enabled edge k+2.
- R2: Reads and writes may alternate on consecutive cycles with no idle cycle. A read issued one or more cycles after a write to the same address returns the newly written word.
- R3: While `hold` is 1, every internal register keeps its value. The command inputs and `wdata` are ignored. Any pending data phase moves to the next edge where `hold` is 0.
- R4: A new command starts only when `cont_burst` is 0, `sel_a_n` is 0, `sel_b` is 1 and `sel_c_n` is 0. If the selects fail, no command starts, but commands already in the pipeline still complete.
- R5: `rdata_oe` is 1 only during read data phases. It is 0 two enabled edges after a write command or a deselected cycle.
- R6: `drv_gate_n` = 1 forces `rdata_oe` to 0 in the same cycle, with no register in between. It does not disturb the pipeline.
- R7: On a write, lane i (bits 9i+8 down to 9i) is updated only when `lane_wr_n[i]` is 0. Lanes whose bit is 1 keep their old contents.
- R8: With `cont_burst` = 1 after a selected load, the block repeats the loaded operation. Step n (n = 1, 2, 3, ...) uses the address whose bits above bit 1 equal the base, and whose low two bits are (base + n) mod 4 when `order_xor` = 0. During a continue, `rd_sel` and the select inputs are ignored, and `lane_wr_n` is taken fresh on each step.
- R9: With `order_xor` = 1, the low two address bits of burst step n are the base low bits XOR (n mod 4).
- R10: A continue after a deselected load, or after reset, starts no operation, and `rdata_oe` stays 0.
- R11: While `rst` is 1 on a rising edge, the pipeline, the burst state and `rdata_oe` are cleared, and pending writes are dropped. Stored words are kept.
- R12: A burst that continues past four words wraps back to the base address and repeats the same four-address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | 1 freezes all registers (stall) |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| cont_burst | input | 1 | 0 loads a new command, 1 continues the burst |
| rd_sel | input | 1 | 1 read, 0 write (sampled on load) |
| lane_wr_n | input | 4 | Per-lane write select, active low |
| order_xor | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | 8 | Word address (width set by package) |
| wdata | input | 36 | Write data for the data phase |
| drv_gate_n | input | 1 | Asynchronous output gate, active low |
| rdata | output | 36 | Read data |
| rdata_oe | output | 1 | Drive enable for the shared data bus |

## Verification
The embedded assertions check on every edge that a stalled edge changes no pipeline state. They also check that a failed select or an orphan continue leaves the command stage empty, that a continue keeps the upper address bits and the operation type of its load, and that the read-valid flag follows the operation reaching the data phase. Only the bench scenarios can show the values involved. These are the words returned after lane-masked writes, the exact linear and interleaved sequences and their wrap, write-then-read forwarding, and the garbage `wdata` ignored during a stall. For these, a behavioural model is compared with the outputs on every cycle.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;

    parameter int ADDR_W    = 8;
    parameter int LANES     = 4;
    parameter int LANE_W    = 9;
    parameter int BURST_LEN = 4;
    parameter int DATA_LAT  = 2;

    localparam int WORD_W = LANES * LANE_W;
    localparam int STEP_W = $clog2(BURST_LEN);
    localparam int DEPTH  = 1 << ADDR_W;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lmask;
    } op_t;

    function automatic logic [ADDR_W-1:0] burst_addr(
        input logic [ADDR_W-1:0] base,
        input logic [STEP_W-1:0] step,
        input logic              xor_order
    );
        logic [STEP_W-1:0] lo;
        if (xor_order) lo = base[STEP_W-1:0] ^ step;
        else           lo = base[STEP_W-1:0] + step;
        return {base[ADDR_W-1:STEP_W], lo};
    endfunction

    function automatic logic chip_selected(input logic a_n, input logic b, input logic c_n);
        return !a_n && b && !c_n;
    endfunction

endpackage

// File: rtl/zbt_burst_gen.sv
module zbt_burst_gen
    import zbt_sram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              cont_burst,
    input  logic              selected,
    input  logic              rd_sel,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              order_xor,
    output op_t               op_q
);

    logic              active_q;
    logic              wr_q;
    logic [ADDR_W-1:0] base_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] step_nx;

    assign step_nx = step_q + STEP_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            wr_q     <= 1'b0;
            base_q   <= '0;
            step_q   <= '0;
            op_q     <= '0;
        end else if (en) begin
            if (!cont_burst) begin
                active_q <= selected;
                op_q.vld <= selected;
                if (selected) begin
                    base_q     <= addr;
                    step_q     <= '0;
                    wr_q       <= !rd_sel;
                    op_q.wr    <= !rd_sel;
                    op_q.addr  <= addr;
                    op_q.lmask <= ~lane_wr_n;
                end
            end else begin
                op_q.vld <= active_q;
                if (active_q) begin
                    step_q     <= step_nx;
                    op_q.wr    <= wr_q;
                    op_q.addr  <= burst_addr(base_q, step_nx, order_xor);
                    op_q.lmask <= ~lane_wr_n;
                end
            end
        end
    end

    // R4
    no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && en && !cont_burst && !selected) |=> !op_q.vld);

    // R10
    dead_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && en && cont_burst && !active_q) |=> !op_q.vld);

    // R8
    burst_page_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && en && cont_burst && active_q) |=>
        (op_q.vld && op_q.wr == $past(wr_q) &&
         op_q.addr[ADDR_W-1:STEP_W] == $past(base_q[ADDR_W-1:STEP_W])));

endmodule

// File: rtl/zbt_op_delay.sv
module zbt_op_delay
    import zbt_sram_pkg::*;
#(
    parameter int STAGES = DATA_LAT - 1
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  op_t  op_i,
    output op_t  op_o
);

    op_t st [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)     st[i] <= '0;
                else if (en) st[i] <= op_i;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)     st[i] <= '0;
                else if (en) st[i] <= st[i-1];
            end
        end
    end

    assign op_o = st[STAGES-1];

endmodule

// File: rtl/zbt_mem_core.sv
module zbt_mem_core
    import zbt_sram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  op_t               op_i,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rd_vld
);

    logic do_wr;
    logic do_rd;

    assign do_wr = !rst && en && op_i.vld && op_i.wr;
    assign do_rd = !rst && en && op_i.vld && !op_i.wr;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (do_wr && op_i.lmask[g])
                store[op_i.addr] <= wdata[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk) begin
            if (do_rd) lane_q <= store[op_i.addr];
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_q;
    end

    always_ff @(posedge clk) begin
        if (rst)     rd_vld <= 1'b0;
        else if (en) rd_vld <= op_i.vld && !op_i.wr;
    end

    // R1
    rd_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && en && op_i.vld && !op_i.wr) |=> rd_vld);

    // R5
    wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && en && !(op_i.vld && !op_i.wr)) |=> !rd_vld);

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_sram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              cont_burst,
    input  logic              rd_sel,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              order_xor,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              drv_gate_n,
    output logic [WORD_W-1:0] rdata,
    output logic              rdata_oe
);

    logic en;
    logic selected;
    logic rd_vld;
    op_t  cmd_op;
    op_t  phase_op;

    assign en       = !hold;
    assign selected = chip_selected(sel_a_n, sel_b, sel_c_n);

    zbt_burst_gen u_burst (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .cont_burst (cont_burst),
        .selected   (selected),
        .rd_sel     (rd_sel),
        .lane_wr_n  (lane_wr_n),
        .addr       (addr),
        .order_xor  (order_xor),
        .op_q       (cmd_op)
    );

    zbt_op_delay #(.STAGES(DATA_LAT - 1)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .op_i (cmd_op),
        .op_o (phase_op)
    );

    zbt_mem_core u_core (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .op_i   (phase_op),
        .wdata  (wdata),
        .rdata  (rdata),
        .rd_vld (rd_vld)
    );

    assign rdata_oe = rd_vld && !drv_gate_n;

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && hold) |=> ($stable(rd_vld) && $stable(phase_op) && $stable(cmd_op)));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!rd_vld && !phase_op.vld && !cmd_op.vld));

endmodule

// File: tb/zbt_sram_tb_top.sv
module zbt_sram_tb_top;
    import zbt_sram_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              hold = 1'b0;
    logic              sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic              cont_burst = 1'b0, rd_sel = 1'b1, order_xor = 1'b0;
    logic              drv_gate_n = 1'b0;
    logic [LANES-1:0]  lane_wr_n = '1;
    logic [ADDR_W-1:0] addr = '0;
    logic [WORD_W-1:0] wdata = '0;
    logic [WORD_W-1:0] rdata;
    logic              rdata_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    zbt_sram dut_i (
        .clk(clk), .rst(rst), .hold(hold), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .cont_burst(cont_burst), .rd_sel(rd_sel),
        .lane_wr_n(lane_wr_n), .order_xor(order_xor), .addr(addr),
        .wdata(wdata), .drv_gate_n(drv_gate_n), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R11";

    // behavioural reference state
    bit               m_act, m_wr;
    int               m_base, m_step;
    bit               p0_v, p0_w, p1_v, p1_w;
    int               p0_a, p1_a;
    logic [LANES-1:0] p0_m, p1_m;
    bit               e_v;
    logic [WORD_W-1:0] e_d;
    logic [WORD_W-1:0] mem_m [int];

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; p0_v = 0; p1_v = 0; e_v = 0; m_step = 0;
        end else if (!hold) begin
            logic [WORD_W-1:0] w;
            int a;
            if (p1_v && p1_w) begin
                w = mem_m.exists(p1_a) ? mem_m[p1_a] : 'x;
                for (int i = 0; i < LANES; i++)
                    if (p1_m[i]) w[i*LANE_W +: LANE_W] = wdata[i*LANE_W +: LANE_W];
                mem_m[p1_a] = w;
            end
            e_v = p1_v && !p1_w;
            if (e_v) e_d = mem_m.exists(p1_a) ? mem_m[p1_a] : 'x;
            p1_v = p0_v; p1_w = p0_w; p1_a = p0_a; p1_m = p0_m;
            if (!cont_burst) begin
                if (!sel_a_n && sel_b && !sel_c_n) begin
                    m_act = 1; m_base = int'(addr); m_step = 0; m_wr = !rd_sel;
                    p0_v = 1; p0_w = m_wr; p0_a = m_base; p0_m = ~lane_wr_n;
                end else begin
                    m_act = 0; p0_v = 0;
                end
            end else if (m_act) begin
                m_step = (m_step + 1) % 4;
                if (order_xor) a = m_base ^ m_step;
                else           a = (m_base & ~3) | ((m_base + m_step) & 3);
                p0_v = 1; p0_w = m_wr; p0_a = a; p0_m = ~lane_wr_n;
            end else begin
                p0_v = 0;
            end
        end
    end

    always @(negedge clk) begin
        bit exp_en;
        exp_en = e_v && !drv_gate_n;
        checks++;
        if (rdata_oe !== exp_en) begin
            errors++;
            $display("FAIL %s rdata_oe actual %b expected %b at %0t", cur_req, rdata_oe, exp_en, $time);
        end else if (exp_en && !$isunknown(e_d)) begin
            checks++;
            if (rdata !== e_d) begin
                errors++;
                $display("FAIL %s rdata actual %h expected %h at %0t", cur_req, rdata, e_d, $time);
            end
        end
    end

    // stimulus
    logic [WORD_W-1:0] dq0 = '0, dq1 = '0;
    int bad_ix = 0;

    function automatic logic [WORD_W-1:0] rnd();
        return WORD_W'({$urandom(), $urandom()});
    endfunction

    task automatic step(input bit cb, input bit ok, input bit rd, input logic [LANES-1:0] bwn,
                        input int a, input logic [WORD_W-1:0] wd,
                        input bit hd = 0, input bit gate_n = 0);
        @(posedge clk); #1;
        hold = hd; drv_gate_n = gate_n; cont_burst = cb; rd_sel = rd;
        lane_wr_n = bwn; addr = ADDR_W'(a);
        if (ok) {sel_a_n, sel_b, sel_c_n} = 3'b010;
        else begin
            case (bad_ix % 3)
                0: {sel_a_n, sel_b, sel_c_n} = 3'b110;
                1: {sel_a_n, sel_b, sel_c_n} = 3'b000;
                default: {sel_a_n, sel_b, sel_c_n} = 3'b011;
            endcase
            bad_ix++;
        end
        if (!hd) begin
            wdata = dq1; dq1 = dq0; dq0 = wd;
        end else begin
            wdata = rnd();
        end
    endtask

    task automatic wr(input int a, input logic [LANES-1:0] bwn = '0);
        step(0, 1, 0, bwn, a, rnd());
    endtask
    task automatic rd(input int a, input bit gate_n = 0);
        step(0, 1, 1, '1, a, rnd(), 0, gate_n);
    endtask
    task automatic idle();
        step(0, 0, 1, '1, $urandom % 256, rnd());
    endtask
    task automatic adv(input logic [LANES-1:0] bwn = '0);
        step(1, bit'($urandom % 2), bit'($urandom % 2), bwn, $urandom % 256, rnd());
    endtask
    task automatic stall();
        step(bit'($urandom % 2), 1, bit'($urandom % 2), '0, $urandom % 256, rnd(), 1);
    endtask
    task automatic flush();
        repeat (3) idle();
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cur_req = "R11";
        repeat (3) idle();
        @(posedge clk); #1; rst = 0;
        flush();

        cur_req = "R1";
        for (int i = 0; i < 16; i++) wr(i);
        for (int i = 0; i < 16; i++) rd(i);
        flush();

        cur_req = "R2";
        for (int i = 0; i < 8; i++) begin wr(32 + i); rd(32 + i); end
        for (int i = 0; i < 6; i++) begin rd(i); wr(40 + i); end
        for (int i = 0; i < 6; i++) rd(40 + i);
        flush();

        cur_req = "R7";
        for (int i = 0; i < 16; i++) wr(i, LANES'(i));
        for (int i = 0; i < 16; i++) rd(i);
        flush();

        cur_req = "R3";
        wr(50); stall(); rd(3); stall(); stall(); wr(51); rd(50); stall(); rd(51);
        stall(); idle(); stall(); idle(); stall(); idle();
        flush();

        cur_req = "R4";
        wr(60); idle(); rd(60); idle(); idle(); wr(61); rd(1); idle(); rd(61); idle();
        flush();

        cur_req = "R5";
        rd(2); wr(62); rd(62); idle(); rd(3); rd(4); wr(63); idle(); rd(63);
        flush();

        cur_req = "R6";
        rd(1, 1); rd(2, 0); rd(3, 1); rd(4, 0);
        step(0, 0, 1, '1, 0, rnd(), 0, 1);
        step(0, 0, 1, '1, 0, rnd(), 0, 1);
        step(0, 0, 1, '1, 0, rnd(), 0, 0);
        flush();

        cur_req = "R8";
        order_xor = 0;
        wr(69); adv(); adv(); adv();
        step(0, 1, 1, '1, 69, rnd()); adv('1); adv('1); adv('1);
        wr(70, 4'b1010); adv(4'b0101); adv(4'b0011); adv(4'b1100);
        rd(70); adv('1); adv('1); adv('1);
        flush();

        cur_req = "R9";
        order_xor = 1;
        wr(102); adv(); adv(); adv();
        rd(102); adv('1); adv('1); adv('1);
        rd(69); adv('1); adv('1); adv('1);
        flush();

        cur_req = "R12";
        order_xor = 0;
        rd(70); repeat (9) adv('1);
        order_xor = 1;
        rd(101); repeat (9) adv('1);
        order_xor = 0;
        flush();

        cur_req = "R10";
        idle(); adv(); adv(); adv();
        rd(5); idle(); adv('1); adv('1);
        flush();

        cur_req = "R11";
        wr(80); rd(5); rd(6);
        @(posedge clk); #1; rst = 1;
        @(posedge clk); #1; rst = 0; dq0 = '0; dq1 = '0;
        adv(); adv(); idle();
        rd(80); flush();

        cur_req = "R2";
        for (int n = 0; n < 400; n++) begin
            int k;
            k = $urandom % 10;
            order_xor = bit'($urandom % 2);
            if (k < 3)      wr($urandom % 16, LANES'($urandom));
            else if (k < 6) rd($urandom % 16, bit'(($urandom % 8) == 0));
            else if (k < 8) adv(LANES'($urandom));
            else if (k < 9) stall();
            else            idle();
        end
        flush();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule